// File: doc/BRIEF.md
# Registered Byte ALU with Status Flags

This block is a two-stage byte arithmetic logic unit. On a rising clock edge it loads two operands and a 4-bit operation code into an operand register stage. The following rising edge loads the computed byte and three status flags into an output register: carry/borrow, signed overflow and zero. The operations are add, increment, subtract, compare, bitwise AND/OR/XOR, complement of the second operand, and arithmetic shifts left and right by a distance from 0 to 7. A clear operation empties the operand registers, so the operation captured after it sees two zero operands.

A new operation can be issued every cycle. The datapath is a fixed two-register pipeline that never stalls, so it has no valid/ready handshake. All pins are plain level signals. A synchronous active-high clear input empties both register stages. The ALU output is not meaningful while that input is high.

Top module: `alu8_flagged`

## Requirements
- R1: When `clr_i` is high at a rising edge, the output register holds y_o=0 and c_o=v_o=z_o=0 after that edge. The operand stage loads zero operands and an idle code 0111 (behaving as an unused code), so the edge after the clear also gives y_o=0 with all flags low.
- R2: Operands and code on a_i, b_i and op_i are captured at one rising edge. Their result is visible on y_o/c_o/v_o/z_o after the next rising edge.
- R3: Code 0000 gives y=(A+B) mod 256 with c=carry out. Code 0001 gives y=(A+1) mod 256 with c=carry out. Code 0010 gives y=(A-B) mod 256 with c=1 when A<B (borrow). For all three, v=1 on signed two's-complement overflow.
- R4: Code 0011 (compare) leaves y_o unchanged. It sets c, v and z from A-B exactly as subtract would.
- R5: Codes 1100, 1101 and 1110 give A AND B, A OR B and A XOR B. For these codes and for codes 0100, 0101 and 1111, c=v=0.
- R6: Code 1111 gives the bitwise inverse of B, and A has no effect.
- R7: Code 0100 shifts A left by B[2:0] positions and fills the vacated low bits with zeros. B[7:3] has no effect.
- R8: Code 0101 shifts A right by B[2:0] positions and copies A[7] into the vacated high bits. B[7:3] has no effect.
- R9: Code 0110 gives y=0 with all flags low. The operation captured at the edge after a clear code has been captured computes with A=0 and B=0, whatever a_i and b_i were.
- R10: For codes 0000–0101 and 1100–1111, z=1 exactly when the 8-bit result is zero. For compare, z=1 exactly when the difference A-B is zero.
- R11: Unused codes 0111, 1000, 1001, 1010 and 1011 give y=0 with c=v=z=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| clr_i | input | 1 | Synchronous clear, active high |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand; bits 2:0 give the shift distance |
| op_i | input | 4 | Operation code |
| y_o | output | 8 | Registered result byte |
| c_o | output | 1 | Registered carry (add/inc) or borrow (sub/cmp) |
| v_o | output | 1 | Registered signed overflow |
| z_o | output | 1 | Registered zero flag |

## Verification
Every result is due after the second rising edge following the cycle in which its inputs were driven. The operand edge comes first, then the output edge. The bench drives inputs and compares outputs on the falling edge. A bench model holds a one-deep operand stage and one output stage, and it advances once per clock. Each comparison therefore meets exactly the vector issued two edges earlier, together with the compare-hold value and the zeroed operands left by a clear. Clear pulses inserted in the middle of a stream are modelled in the same way, including the idle cycle that follows each of them.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_ADD  = 4'b0000;
  localparam logic [OPW-1:0] OP_INC  = 4'b0001;
  localparam logic [OPW-1:0] OP_SUB  = 4'b0010;
  localparam logic [OPW-1:0] OP_CMP  = 4'b0011;
  localparam logic [OPW-1:0] OP_ASL  = 4'b0100;
  localparam logic [OPW-1:0] OP_ASR  = 4'b0101;
  localparam logic [OPW-1:0] OP_CLR  = 4'b0110;
  localparam logic [OPW-1:0] OP_IDLE = 4'b0111;
  localparam logic [OPW-1:0] OP_AND  = 4'b1100;
  localparam logic [OPW-1:0] OP_OR   = 4'b1101;
  localparam logic [OPW-1:0] OP_XOR  = 4'b1110;
  localparam logic [OPW-1:0] OP_CPL  = 4'b1111;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
  } alu_flags_t;

  function automatic logic op_is_unused(input logic [OPW-1:0] op);
    return (op == OP_IDLE) || (op[3:2] == 2'b10);
  endfunction

  function automatic logic op_clears_cv(input logic [OPW-1:0] op);
    return (op[3:2] == 2'b11) || (op == OP_ASL) || (op == OP_ASR);
  endfunction

endpackage

// File: rtl/alu8_operand_stage.sv
module alu8_operand_stage
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           clr_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [OPW-1:0] op_i,
  output logic [W-1:0]   a_q,
  output logic [W-1:0]   b_q,
  output logic [OPW-1:0] op_q
);

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      a_q  <= '0;
      b_q  <= '0;
      op_q <= OP_IDLE;
    end else begin
      op_q <= op_i;
      if (op_q == OP_CLR) begin
        a_q <= '0;
        b_q <= '0;
      end else begin
        a_q <= a_i;
        b_q <= b_i;
      end
    end
  end

  assert_clr_zeroes_operands_R9: assert property (@(posedge clk_i) disable iff (clr_i)
    (op_q == OP_CLR) |=> (a_q == '0) && (b_q == '0));

endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
  parameter int W = 8,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  din_i,
  input  logic [SW-1:0] amt_i,
  input  logic          right_i,
  output logic [W-1:0]  dout_o
);

  logic [W-1:0] stg [SW+1];

  assign stg[0] = din_i;

  for (genvar gi = 0; gi < SW; gi++) begin : g_stage
    localparam int SH = 1 << gi;
    logic [W-1:0] shl, shr;
    assign shl = {stg[gi][W-1-SH:0], {SH{1'b0}}};
    assign shr = {{SH{stg[gi][W-1]}}, stg[gi][W-1:SH]};
    assign stg[gi+1] = amt_i[gi] ? (right_i ? shr : shl) : stg[gi];
  end

  assign dout_o = stg[SW];

  always_comb begin
    if (!right_i && amt_i != '0) begin
      assert_asl_zero_fill_R7: assert (dout_o[0] == 1'b0);
    end
    if (right_i) begin
      assert_asr_keeps_sign_R8: assert (dout_o[W-1] == din_i[W-1]);
    end
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int W = 8,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   y_prev_i,
  output logic [W-1:0]   y_o,
  output alu_flags_t     flags_o
);

  logic [W-1:0] addend;
  logic [W:0]   sum;
  logic [W:0]   diff;
  logic [W-1:0] sh_out;
  logic         add_ovf, sub_ovf;

  assign addend  = (op_i == OP_INC) ? W'(1) : b_i;
  assign sum     = {1'b0, a_i} + {1'b0, addend};
  assign diff    = {1'b0, a_i} - {1'b0, b_i};
  assign add_ovf = (a_i[W-1] == addend[W-1]) && (sum[W-1] != a_i[W-1]);
  assign sub_ovf = (a_i[W-1] != b_i[W-1]) && (diff[W-1] != a_i[W-1]);

  alu8_shifter #(.W(W)) u_shift (
    .din_i   (a_i),
    .amt_i   (b_i[SW-1:0]),
    .right_i (op_i == OP_ASR),
    .dout_o  (sh_out)
  );

  always_comb begin
    y_o     = '0;
    flags_o = '0;
    case (op_i)
      OP_ADD, OP_INC: begin
        y_o       = sum[W-1:0];
        flags_o.c = sum[W];
        flags_o.v = add_ovf;
        flags_o.z = (sum[W-1:0] == '0);
      end
      OP_SUB: begin
        y_o       = diff[W-1:0];
        flags_o.c = diff[W];
        flags_o.v = sub_ovf;
        flags_o.z = (diff[W-1:0] == '0);
      end
      OP_CMP: begin
        y_o       = y_prev_i;
        flags_o.c = diff[W];
        flags_o.v = sub_ovf;
        flags_o.z = (diff[W-1:0] == '0);
      end
      OP_ASL, OP_ASR: begin
        y_o       = sh_out;
        flags_o.z = (sh_out == '0);
      end
      OP_AND: begin
        y_o       = a_i & b_i;
        flags_o.z = ((a_i & b_i) == '0);
      end
      OP_OR: begin
        y_o       = a_i | b_i;
        flags_o.z = ((a_i | b_i) == '0);
      end
      OP_XOR: begin
        y_o       = a_i ^ b_i;
        flags_o.z = ((a_i ^ b_i) == '0);
      end
      OP_CPL: begin
        y_o       = ~b_i;
        flags_o.z = (b_i == '1);
      end
      default: begin
        y_o     = '0;
        flags_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           clr_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [OPW-1:0] op_i,
  output logic [W-1:0]   y_o,
  output logic           c_o,
  output logic           v_o,
  output logic           z_o
);

  logic [W-1:0]   a_q, b_q;
  logic [OPW-1:0] op_q;
  logic [W-1:0]   y_next;
  alu_flags_t     fl_next;

  alu8_operand_stage #(.W(W)) u_opnd (
    .clk_i (clk_i),
    .clr_i (clr_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (op_i),
    .a_q   (a_q),
    .b_q   (b_q),
    .op_q  (op_q)
  );

  alu8_datapath #(.W(W)) u_dp (
    .a_i      (a_q),
    .b_i      (b_q),
    .op_i     (op_q),
    .y_prev_i (y_o),
    .y_o      (y_next),
    .flags_o  (fl_next)
  );

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      y_o <= '0;
      c_o <= 1'b0;
      v_o <= 1'b0;
      z_o <= 1'b0;
    end else begin
      y_o <= y_next;
      c_o <= fl_next.c;
      v_o <= fl_next.v;
      z_o <= fl_next.z;
    end
  end

  assert_clear_outputs_R1: assert property (@(posedge clk_i)
    clr_i |=> (y_o == '0) && !c_o && !v_o && !z_o);

  assert_cmp_holds_y_R4: assert property (@(posedge clk_i) disable iff (clr_i)
    (op_q == OP_CMP) |=> (y_o == $past(y_o)));

  assert_logic_shift_no_cv_R5: assert property (@(posedge clk_i) disable iff (clr_i)
    op_clears_cv(op_q) |=> !c_o && !v_o);

  assert_zero_flag_tracks_y_R10: assert property (@(posedge clk_i) disable iff (clr_i)
    (!op_is_unused(op_q) && op_q != OP_CMP && op_q != OP_CLR) |=> (z_o == (y_o == '0)));

  assert_unused_quiet_R11: assert property (@(posedge clk_i) disable iff (clr_i)
    op_is_unused(op_q) |=> (y_o == '0) && !c_o && !v_o && !z_o);

endmodule

// File: tb/alu8_flagged_tb.sv
module alu8_flagged_tb;

  logic       clk = 1'b0;
  logic       clr_i = 1'b1;
  logic [7:0] a_i = '0, b_i = '0;
  logic [3:0] op_i = 4'b0111;
  logic [7:0] y_o;
  logic       c_o, v_o, z_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu8_flagged u_dut (
    .clk_i (clk), .clr_i (clr_i), .a_i (a_i), .b_i (b_i), .op_i (op_i),
    .y_o (y_o), .c_o (c_o), .v_o (v_o), .z_o (z_o)
  );

  // bench model: operand stage and output stage
  logic [7:0]  s_a = '0, s_b = '0;
  logic [3:0]  s_op = 4'b0111;
  bit          s_zeroed = 1'b0;
  logic [10:0] m_out = '0;   // {y, c, v, z}
  string       m_tag = "R1";
  bit          m_valid = 1'b0;

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'b0000, 4'b0001, 4'b0010: return "R3";
      4'b0011: return "R4";
      4'b1100, 4'b1101, 4'b1110: return "R5";
      4'b1111: return "R6";
      4'b0100: return "R7";
      4'b0101: return "R8";
      4'b0110: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [10:0] expect_of(input logic [7:0] a, input logic [7:0] b,
                                            input logic [3:0] op, input logic [7:0] yprev);
    int ia, ib, r, sa, sb, sr, n;
    logic [7:0] y;
    logic c, v, z;
    ia = int'(a); ib = int'(b);
    sa = (ia > 127) ? ia - 256 : ia;
    sb = (ib > 127) ? ib - 256 : ib;
    n = ib % 8;
    c = 0; v = 0; y = 0; z = 0;
    case (op)
      4'b0000, 4'b0001: begin
        if (op == 4'b0001) begin ib = 1; sb = 1; end
        r = ia + ib; sr = sa + sb;
        y = 8'(r); c = (r > 255); v = (sr > 127) || (sr < -128); z = (y == 0);
      end
      4'b0010, 4'b0011: begin
        r = ia - ib; sr = sa - sb;
        y = 8'(r); c = (ia < ib); v = (sr > 127) || (sr < -128); z = (y == 0);
        if (op == 4'b0011) y = yprev;
      end
      4'b0100: begin y = 8'((ia * (1 << n)) % 256); z = (y == 0); end
      4'b0101: begin
        y = a;
        for (int k = 0; k < n; k++) y = {a[7], y[7:1]};
        z = (y == 0);
      end
      4'b1100: begin y = a & b; z = (y == 0); end
      4'b1101: begin y = a | b; z = (y == 0); end
      4'b1110: begin y = a ^ b; z = (y == 0); end
      4'b1111: begin y = ~b; z = (y == 0); end
      default: begin y = 0; end
    endcase
    return {y, c, v, z};
  endfunction

  task automatic step(input logic [7:0] a, input logic [7:0] b,
                      input logic [3:0] op, input bit clr);
    @(negedge clk);
    if (m_valid) begin
      n_vec++;
      if (y_o !== m_out[10:3]) begin
        n_bad++;
        $display("FAIL %s,R2 y: actual %02h expected %02h", m_tag, y_o, m_out[10:3]);
      end else if ({c_o, v_o} !== m_out[2:1]) begin
        n_bad++;
        $display("FAIL %s,R2 c/v: actual %b%b expected %b", m_tag, c_o, v_o, m_out[2:1]);
      end else if (z_o !== m_out[0]) begin
        n_bad++;
        $display("FAIL R10 (%s) z: actual %b expected %b", m_tag, z_o, m_out[0]);
      end
    end
    a_i = a; b_i = b; op_i = op; clr_i = clr;
    if (clr) begin
      m_out = '0; m_tag = "R1";
      s_a = '0; s_b = '0; s_op = 4'b0111; s_zeroed = 1'b0;
    end else begin
      m_out = expect_of(s_a, s_b, s_op, m_out[10:3]);
      m_tag = s_zeroed ? "R9" : req_of(s_op);
      s_zeroed = (s_op == 4'b0110);
      if (s_zeroed) begin s_a = '0; s_b = '0; end
      else begin s_a = a; s_b = b; end
      s_op = op;
    end
    m_valid = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0A1C));
    step(8'h12, 8'h34, 4'b0000, 1);
    step(8'h00, 8'h00, 4'b0000, 1);      // R1 reset state checked here
    // directed corners
    step(8'h7F, 8'h01, 4'b0000, 0);      // R3 signed overflow
    step(8'hFF, 8'h01, 4'b0000, 0);      // R3 carry, zero
    step(8'hFF, 8'h99, 4'b0001, 0);      // R3 inc wraps
    step(8'h00, 8'h01, 4'b0010, 0);      // R3 borrow
    step(8'h80, 8'h01, 4'b0010, 0);      // R3 sub overflow
    step(8'h55, 8'h55, 4'b0011, 0);      // R4 cmp equal, y held
    step(8'h10, 8'h20, 4'b0011, 0);      // R4 cmp borrow
    step(8'h81, 8'hFB, 4'b0100, 0);      // R7 shift by 3, B high ignored
    step(8'h80, 8'h0F, 4'b0101, 0);      // R8 sign fill by 7
    step(8'h40, 8'hF7, 4'b0101, 0);      // R8 positive by 7
    step(8'hA5, 8'h00, 4'b0100, 0);      // R7 shift by 0
    step(8'hDE, 8'hFF, 4'b1111, 0);      // R6 cpl to zero
    step(8'hF0, 8'h3C, 4'b1100, 0);      // R5 and
    step(8'hF0, 8'h0F, 4'b1110, 0);      // R5 xor
    step(8'h00, 8'h00, 4'b1101, 0);      // R5 or zero
    step(8'h33, 8'h44, 4'b0110, 0);      // R9 clr
    step(8'h05, 8'h06, 4'b0000, 0);      // R9 operands zeroed
    step(8'h05, 8'h06, 4'b0000, 0);
    for (int u = 7; u < 12; u++) begin
      logic [3:0] uop;
      uop = (u == 7) ? 4'b0111 : 4'(u);
      step(8'hFF, 8'hFF, uop, 0);        // R11 unused codes
    end
    step(8'h01, 8'h02, 4'b0000, 1);      // mid-run clear, R1
    // constrained random stream
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] rop;
      logic [7:0] ra, rb;
      rop = 4'($urandom_range(0, 15));
      ra = 8'($urandom);
      rb = 8'($urandom);
      if ($urandom_range(0, 7) == 0) ra = ($urandom_range(0, 1) != 0) ? 8'h80 : 8'h7F;
      if ($urandom_range(0, 7) == 0) rb = ($urandom_range(0, 1) != 0) ? 8'hFF : 8'h00;
      step(ra, rb, rop, ($urandom_range(0, 99) == 0));
    end
    step(8'h00, 8'h00, 4'b0111, 0);
    step(8'h00, 8'h00, 4'b0111, 0);
    step(8'h00, 8'h00, 4'b0111, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule